// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block sits between the oscillator input of a small 8-bit controller and the rest of the chip. It halves the oscillator clock into a timing tick, groups six ticks into one machine cycle, and hands out clock enables: one for the processor core and one for the peripherals and the interrupt logic. It also produces an enable for the oscillator itself and a strobe that marks the end of each machine cycle.

Software writes the power-control register, which gives the block a write strobe with an idle request bit and a power-down request bit. In idle only the core enable is removed, and any pending interrupt or a high reset pin brings the core back. Power-down stops every enable, including the oscillator enable, and only the reset pin ends it. The external reset pin is synchronised and then sampled at one fixed state of each machine cycle. The internal reset is accepted only after two consecutive high samples, so short pulses are filtered out. The block also drives the constant values that the register file loads during reset.

A separate active-low power-on input clears the block's own registers. The power-control register itself is outside this block. It reads the mode back through the two mode flags, and the flags fall by themselves on wakeup.

Top module: `pwrclk_ctrl`

## Requirements
- R1: In run mode, coreClkEn and perClkEn are each high for exactly one oscillator cycle out of every two, and never high on two cycles in a row.
- R2: While the oscillator enable is high, mcStrobe pulses once every 12 oscillator cycles, which is six divided ticks.
- R3: A power-control write with the idle bit set (and the power-down bit clear) in run mode sets idleFlag. In idle, coreClkEn stays low while perClkEn and mcStrobe keep their run-mode rates.
- R4: In idle, a high irqPending returns the block to run mode on the next clock. idleFlag clears and coreClkEn resumes.
- R5: A power-control write with the power-down bit set in run mode sets pdFlag. In power-down, oscRunEn, coreClkEn, perClkEn and mcStrobe all stay low.
- R6: In power-down, irqPending has no effect. Power-down ends, and pdFlag clears, only when the synchronised reset pin is high.
- R7: A single write with both the idle and the power-down bits set enters power-down: pdFlag=1 and idleFlag=0.
- R8: sysRst rises only after the reset pin is seen high at two consecutive machine-cycle sample points. A pin pulse shorter than one machine cycle never raises sysRst.
- R9: sysRst falls at the first machine-cycle sample point that sees the reset pin low, which is within 14 oscillator cycles of the pin falling.
- R10: The reset-value outputs read as follows: ports FFh, stack pointer 07h, all other special registers 00h, and a power-control keep mask of 10h, so that only bit 4 survives reset.
- R11: In idle, a high reset pin also returns the block to run mode, whether or not the reset is then accepted.
- R12: Power-control writes are ignored while sysRst is high and while the block is in idle or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on clear of this block, active low, asynchronous |
| rstPin | input | 1 | External reset pin, active high, asynchronous |
| pconWr | input | 1 | Power-control register write strobe |
| idleBit | input | 1 | Idle request bit carried with the write |
| pdBit | input | 1 | Power-down request bit carried with the write |
| irqPending | input | 1 | An enabled interrupt is pending |
| coreClkEn | output | 1 | Core clock enable, one oscillator cycle wide |
| perClkEn | output | 1 | Peripheral and interrupt clock enable |
| oscRunEn | output | 1 | Oscillator run enable |
| mcStrobe | output | 1 | End-of-machine-cycle strobe |
| sysRst | output | 1 | Filtered internal reset, active high |
| idleFlag | output | 1 | Idle mode active |
| pdFlag | output | 1 | Power-down mode active |
| rvPort | output | 8 | Reset value for the port latches |
| rvStack | output | 8 | Reset value for the stack pointer |
| rvSfr | output | 8 | Reset value for the other special registers |
| rvPconKeep | output | 8 | Mask of power-control bits kept through reset |

## Verification
A write or an interrupt changes the mode on the clock edge that captures it. A reset-pin wake needs three edges: two for the synchroniser and one for the mode register. The enables move on the following cycle. Reset acceptance can take up to about 26 oscillator cycles after the pin rises, because it depends on where the sample point falls, and release can take up to 14 cycles after the pin falls. For that reason the checks hold the pin for 36 cycles and wait 16 cycles before they sample. Rates are counted over windows of whole machine cycles, starting two cycles after a mode change, so each count has one exact expected value whatever the phase.

// File: rtl/pwrclk_pkg.sv
package pwrclk_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DOWN = 2'd2
  } pwrMode_e;

  typedef struct packed {
    logic runCore;
    logic runPeriph;
    logic runOsc;
  } ctlStrobe_t;

  typedef struct packed {
    logic pinHigh;
    logic rstActive;
  } dpStatus_t;
endpackage

// File: rtl/pwrclk_timing.sv
module pwrclk_timing
  import pwrclk_pkg::*;
#(
  parameter int STATES_PER_MC = 6,
  parameter int SAMPLE_STATE  = 4,
  parameter int RST_SAMPLES   = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstPin,
  input  ctlStrobe_t ctl,
  output dpStatus_t  stat,
  output logic       coreClkEn,
  output logic       perClkEn,
  output logic       oscRunEn,
  output logic       mcStrobe,
  output logic       sysRst
);
  localparam int PH_W = (STATES_PER_MC > 1) ? $clog2(STATES_PER_MC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STATES_PER_MC - 1);
  localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_STATE);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinHigh;
  logic                   halfPh;
  logic                   divTick;
  logic [PH_W-1:0]        phase;
  logic                   sampleEdge;
  logic [RST_SAMPLES-1:0] smpHist;
  logic [RST_SAMPLES-1:0] nextHist;
  logic                   rstReg;

  // pin synchroniser
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rstPin};
  end
  assign pinHigh = syncQ[SYNC_STAGES-1];

  // divide-by-two tick, frozen while the oscillator is stopped
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           halfPh <= 1'b0;
    else if (ctl.runOsc) halfPh <= ~halfPh;
  end
  assign divTick = ctl.runOsc & halfPh;

  // state counter within the machine cycle
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) phase <= '0;
    else if (divTick) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
  end
  assign sampleEdge = divTick && (phase == PH_SMP);

  // reset sample history: accept only a full run of high samples
  generate
    if (RST_SAMPLES == 1) begin : g_single
      assign nextHist = pinHigh;
    end else begin : g_multi
      assign nextHist = {smpHist[RST_SAMPLES-2:0], pinHigh};
    end
  endgenerate

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      smpHist <= '0;
      rstReg  <= 1'b0;
    end else if (sampleEdge) begin
      smpHist <= nextHist;
      rstReg  <= &nextHist;
    end
  end

  assign coreClkEn      = divTick & ctl.runCore;
  assign perClkEn       = divTick & ctl.runPeriph;
  assign oscRunEn       = ctl.runOsc;
  assign mcStrobe       = divTick && (phase == PH_LAST);
  assign sysRst         = rstReg;
  assign stat.pinHigh   = pinHigh;
  assign stat.rstActive = rstReg;

  // R1: enables never on two consecutive cycles
  assert_core_spacing_R1: assert property (@(posedge clk) disable iff (!porN)
    coreClkEn |=> !coreClkEn);
  assert_per_spacing_R1: assert property (@(posedge clk) disable iff (!porN)
    perClkEn |=> !perClkEn);
  // R8: acceptance follows a high sample
  assert_rst_needs_high_R8: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstReg) |-> $past(pinHigh));
  // R9: release follows a low sample
  assert_rst_release_R9: assert property (@(posedge clk) disable iff (!porN)
    $fell(rstReg) |-> !$past(pinHigh));
endmodule

// File: rtl/pwrclk_modectl.sv
module pwrclk_modectl
  import pwrclk_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       pconWr,
  input  logic       idleBit,
  input  logic       pdBit,
  input  logic       irqPending,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output logic       idleFlag,
  output logic       pdFlag
);
  pwrMode_e mode, modeNext;
  logic     wrOk;

  assign wrOk = pconWr && !stat.rstActive;

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_RUN: begin
        if (wrOk && pdBit)        modeNext = MODE_DOWN;
        else if (wrOk && idleBit) modeNext = MODE_IDLE;
      end
      MODE_IDLE: if (stat.pinHigh || irqPending) modeNext = MODE_RUN;
      MODE_DOWN: if (stat.pinHigh)               modeNext = MODE_RUN;
      default:   modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) mode <= MODE_RUN;
    else       mode <= modeNext;
  end

  assign ctl.runCore   = (mode == MODE_RUN);
  assign ctl.runPeriph = (mode != MODE_DOWN);
  assign ctl.runOsc    = (mode != MODE_DOWN);
  assign idleFlag      = (mode == MODE_IDLE);
  assign pdFlag        = (mode == MODE_DOWN);

  // R6: power-down holds until the synchronised pin is high
  assert_pd_sticky_R6: assert property (@(posedge clk) disable iff (!porN)
    (mode == MODE_DOWN && !stat.pinHigh) |=> (mode == MODE_DOWN));
  // R7: power-down wins over idle in one write
  assert_pd_precedence_R7: assert property (@(posedge clk) disable iff (!porN)
    (mode == MODE_RUN && pconWr && pdBit && idleBit && !stat.rstActive) |=> (mode == MODE_DOWN));
  // R12: writes during reset leave the mode alone
  assert_wr_in_reset_R12: assert property (@(posedge clk) disable iff (!porN)
    (mode == MODE_RUN && stat.rstActive) |=> (mode == MODE_RUN));
endmodule

// File: rtl/pwrclk_ctrl.sv
module pwrclk_ctrl
  import pwrclk_pkg::*;
#(
  parameter int          STATES_PER_MC = 6,
  parameter int          SAMPLE_STATE  = 4,
  parameter int          RST_SAMPLES   = 2,
  parameter int          SYNC_STAGES   = 2,
  parameter logic [7:0]  PORT_RV       = 8'hFF,
  parameter logic [7:0]  STACK_RV      = 8'h07,
  parameter logic [7:0]  SFR_RV        = 8'h00,
  parameter logic [7:0]  PCON_KEEP     = 8'h10
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstPin,
  input  logic       pconWr,
  input  logic       idleBit,
  input  logic       pdBit,
  input  logic       irqPending,
  output logic       coreClkEn,
  output logic       perClkEn,
  output logic       oscRunEn,
  output logic       mcStrobe,
  output logic       sysRst,
  output logic       idleFlag,
  output logic       pdFlag,
  output logic [7:0] rvPort,
  output logic [7:0] rvStack,
  output logic [7:0] rvSfr,
  output logic [7:0] rvPconKeep
);
  ctlStrobe_t ctl;
  dpStatus_t  stat;

  pwrclk_modectl u_ctl (
    .clk(clk), .porN(porN), .pconWr(pconWr), .idleBit(idleBit), .pdBit(pdBit),
    .irqPending(irqPending), .stat(stat), .ctl(ctl),
    .idleFlag(idleFlag), .pdFlag(pdFlag)
  );

  pwrclk_timing #(
    .STATES_PER_MC(STATES_PER_MC), .SAMPLE_STATE(SAMPLE_STATE),
    .RST_SAMPLES(RST_SAMPLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .porN(porN), .rstPin(rstPin), .ctl(ctl), .stat(stat),
    .coreClkEn(coreClkEn), .perClkEn(perClkEn), .oscRunEn(oscRunEn),
    .mcStrobe(mcStrobe), .sysRst(sysRst)
  );

  assign rvPort     = PORT_RV;
  assign rvStack    = STACK_RV;
  assign rvSfr      = SFR_RV;
  assign rvPconKeep = PCON_KEEP;

  // R3: core stays gated throughout idle
  assert_idle_gates_core_R3: assert property (@(posedge clk) disable iff (!porN)
    idleFlag |-> !coreClkEn);
  // R5: nothing runs in power-down
  assert_pd_all_off_R5: assert property (@(posedge clk) disable iff (!porN)
    pdFlag |-> (!oscRunEn && !perClkEn && !coreClkEn && !mcStrobe));
  // flags are exclusive
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!porN)
    !(idleFlag && pdFlag));
endmodule

// File: tb/sim_pwrclk_ctrl.sv
module sim_pwrclk_ctrl;
  logic clk = 1'b0;
  logic porN = 1'b0, rstPin = 1'b0, pconWr = 1'b0, idleBit = 1'b0, pdBit = 1'b0, irqPending = 1'b0;
  logic coreClkEn, perClkEn, oscRunEn, mcStrobe, sysRst, idleFlag, pdFlag;
  logic [7:0] rvPort, rvStack, rvSfr, rvPconKeep;

  always #5 clk = ~clk;

  pwrclk_ctrl u0 (.*);

  typedef struct {string req; string what; int val;} item_t;
  item_t expQ[$];
  int    obsQ[$];
  event  obsEv;
  int    nPass = 0, nTotal = 0;
  bit    finished = 1'b0;

  // monitor: pops expected/observed pairs and compares
  initial forever begin
    @(obsEv);
    while (obsQ.size() > 0 && expQ.size() > 0) begin
      item_t e;
      int o;
      e = expQ.pop_front();
      o = obsQ.pop_front();
      nTotal++;
      if (o == e.val) nPass++;
      else $display("FAIL %s %s actual=%0d expected=%0d", e.req, e.what, o, e.val);
    end
  end

  // driver side: push expectation, then the measured result
  task automatic chk(input string req, input string what, input int expv, input int actv);
    expQ.push_back('{req, what, expv});
    obsQ.push_back(actv);
    ->obsEv;
    #0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic countWin(input int n, output int core, output int per, output int mc, output int rst);
    core = 0; per = 0; mc = 0; rst = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      core += int'(coreClkEn); per += int'(perClkEn);
      mc += int'(mcStrobe);    rst += int'(sysRst);
    end
  endtask

  task automatic writePcon(input logic idl, input logic pd);
    @(negedge clk);
    pconWr = 1'b1; idleBit = idl; pdBit = pd;
    @(negedge clk);
    pconWr = 1'b0; idleBit = 1'b0; pdBit = 1'b0;
    cyc(2);
  endtask

  task automatic pinPulse(input int hi, input int lo);
    @(negedge clk); rstPin = 1'b1;
    cyc(hi);
    rstPin = 1'b0;
    cyc(lo);
  endtask

  initial begin
    int c, p, m, r;
    cyc(5);
    porN = 1'b1;
    cyc(4);

    chk("R10", "reset flags {rst,idle,pd,osc}", 1, int'({sysRst, idleFlag, pdFlag, oscRunEn}));
    chk("R10", "port value", 8'hFF, int'(rvPort));
    chk("R10", "stack value", 8'h07, int'(rvStack));
    chk("R10", "sfr value", 8'h00, int'(rvSfr));
    chk("R10", "pcon keep mask", 8'h10, int'(rvPconKeep));

    countWin(24, c, p, m, r);
    chk("R1", "run core ticks/24", 12, c);
    chk("R1", "run periph ticks/24", 12, p);
    chk("R2", "run mc strobes/24", 2, m);

    // idle
    writePcon(1'b1, 1'b0);
    chk("R3", "idleFlag", 1, int'(idleFlag));
    countWin(24, c, p, m, r);
    chk("R3", "idle core ticks", 0, c);
    chk("R3", "idle periph ticks", 12, p);
    chk("R3", "idle mc strobes", 2, m);
    writePcon(1'b0, 1'b1);
    chk("R12", "pd write in idle {idle,pd}", 2, int'({idleFlag, pdFlag}));
    @(negedge clk); irqPending = 1'b1;
    @(negedge clk); irqPending = 1'b0;
    cyc(1);
    chk("R4", "idleFlag after irq", 0, int'(idleFlag));
    countWin(24, c, p, m, r);
    chk("R4", "core ticks after wake", 12, c);

    // power-down
    writePcon(1'b0, 1'b1);
    chk("R5", "pdFlag/osc {pd,osc}", 2, int'({pdFlag, oscRunEn}));
    countWin(24, c, p, m, r);
    chk("R5", "pd total enables", 0, c + p + m);
    @(negedge clk); irqPending = 1'b1;
    cyc(3); irqPending = 1'b0;
    chk("R6", "pdFlag after irq", 1, int'(pdFlag));
    @(negedge clk); rstPin = 1'b1;
    cyc(36);
    chk("R6", "pdFlag after pin", 0, int'(pdFlag));
    chk("R8", "sysRst after 36 high", 1, int'(sysRst));
    rstPin = 1'b0;
    cyc(16);
    chk("R9", "sysRst after release", 0, int'(sysRst));

    // writes during reset
    @(negedge clk); rstPin = 1'b1;
    cyc(36);
    chk("R8", "sysRst held", 1, int'(sysRst));
    writePcon(1'b1, 1'b0);
    chk("R12", "idleFlag after write in reset", 0, int'(idleFlag));
    rstPin = 1'b0;
    cyc(16);

    // both bits
    writePcon(1'b1, 1'b1);
    chk("R7", "both bits {idle,pd}", 1, int'({idleFlag, pdFlag}));
    pinPulse(36, 16);
    chk("R7", "back to run {idle,pd}", 0, int'({idleFlag, pdFlag}));

    // glitch
    @(negedge clk); rstPin = 1'b1;
    cyc(8);
    rstPin = 1'b0;
    countWin(40, c, p, m, r);
    chk("R8", "sysRst cycles after short pulse", 0, r);

    // idle left by the pin
    writePcon(1'b1, 1'b0);
    chk("R11", "idleFlag set", 1, int'(idleFlag));
    @(negedge clk); rstPin = 1'b1;
    cyc(4);
    rstPin = 1'b0;
    chk("R11", "idleFlag after pin", 0, int'(idleFlag));
    countWin(24, c, p, m, r);
    chk("R11", "core ticks after pin wake", 12, c);
    chk("R8", "no reset from short wake pulse", 0, r);

    ->obsEv;
    #1;
    finished = 1'b1;
    $display("%0d/%0d checks passed", nPass, nTotal);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nTotal++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nPass, nTotal);
      $finish;
    end
  end
endmodule